// File: doc/BRIEF.md
# Two-Byte Receive Byte-Order Aligner

This block sits behind a receive deserializer that delivers two bytes per beat, an upper byte and a lower byte, where the lower byte is the earlier one in time. Its job is to bring a chosen ordering marker into the lower-byte position. Each rising edge of the word-sync status input starts a new search. The first beat that carries the marker is handled in one of two ways. If the marker sits in the lower byte, the stream is already ordered and passes through unchanged. If it sits in the upper byte, the block inserts one programmable pad byte ahead of it. From then on the stream runs one byte behind its input, and the extra byte is kept in an internal hold register. In both cases the ordered-status output goes high.

The byte width is a parameter: 8, 9 or 10 bits. In 9-bit use each byte is a control-detect flag in its top bit followed by eight data bits. The marker can be a single byte or a two-byte pair. Data moves on valid/ready handshakes. The block adds no buffering: `m_valid` follows `s_valid`, `s_ready` follows `m_ready`, and only a beat that is actually transferred can advance the search or the slip state. While a beat stalls, the output word depends only on that held beat and on state that stays frozen, so it does not change.

Top module: `byte_order_aligner`

## Requirements
- R1: While reset is held, and in the first beats after it, `ordered_o` is 0 and the stream passes through unshifted (`m_data == s_data`).
- R2: A rising edge of `sync_i` arms a search. The search covers the beat presented in that same cycle and every later transferred beat, until a match is found.
- R3: In single-byte mode (`cfg_pair_i`=0) the marker is `cfg_mark_i[W-1:0]`. A lower-byte match passes the beat through unchanged, and `ordered_o` is 1 from the cycle after that beat's transfer.
- R4: An upper-byte match in an armed beat outputs `cfg_pad_i` in the upper byte and the input's lower byte in the lower byte. The input's upper byte is held, and `ordered_o` is 1 from the next cycle.
- R5: After a pad insertion, each transferred output beat has the held byte in its lower byte and the current input lower byte in its upper byte. The current input upper byte becomes the new held byte.
- R6: Only the first match after a rising edge is acted on. Later marker bytes in either position pass without any pad until `sync_i` falls and rises again.
- R7: While `sync_i` is 0 the output is unshifted pass-through. `ordered_o` is 0 from the cycle after `sync_i` is sampled low. The slip state and any pending search are dropped.
- R8: In pair mode (`cfg_pair_i`=1) the marker pair is first byte A=`cfg_mark_i[W-1:0]` and second byte B=`cfg_mark_i[2W-1:W]`. A lower-position match needs the whole word to be {B,A}. An upper-position match needs the upper byte to equal A. A word with A in the lower byte but not B in the upper byte is not a match.
- R9: In single-byte mode, when both bytes of an armed beat equal the marker, the lower byte wins because it is earlier. No pad is inserted.
- R10: `m_valid` equals `s_valid` and `s_ready` equals `m_ready`. A beat that is not transferred changes neither the hold byte nor the slip state, and it does not consume a pending search.
- R11: The two-byte word puts the upper byte in bits [2W-1:W] and the lower byte in bits [W-1:0]. With W=9, bit 8 of each byte is the control flag. The marker comparison includes that flag, so a byte with the same data bits but a different flag does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Word-sync status; a rising edge arms a search |
| cfg_pair_i | input | 1 | 1 = two-byte marker, 0 = single-byte marker |
| cfg_mark_i | input | 2*BYTE_W | Marker: first byte in the low half, second byte in the high half |
| cfg_pad_i | input | BYTE_W | Pad byte inserted on an upper-position match |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted (equals m_ready) |
| s_data | input | 2*BYTE_W | Input word {upper, lower} |
| m_valid | output | 1 | Output beat valid (equals s_valid) |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 2*BYTE_W | Output word {upper, lower} |
| ordered_o | output | 1 | Byte-order-found status |

## Verification
The assertions assume that `s_data` and the configuration pins stay steady while a beat stalls with `s_valid` high and `m_ready` low. They also assume that `cfg_mark_i` and `cfg_pad_i` do not change in the middle of a search. The stimulus changes inputs only on the falling clock edge and holds a stalled beat's data until the beat is transferred. It changes the marker mode only while `sync_i` is low or in the cycle of a fresh rising edge.

// File: rtl/bo_pkg.sv
package bo_pkg;

  typedef enum logic [1:0] {
    MT_NONE = 2'd0,
    MT_LOW  = 2'd1,
    MT_HIGH = 2'd2
  } match_e;

endpackage

// File: rtl/bo_marker_cmp.sv
module bo_marker_cmp
  import bo_pkg::*;
#(
  parameter int BYTE_W = 9
) (
  input  logic [BYTE_W-1:0]   hi_i,
  input  logic [BYTE_W-1:0]   lo_i,
  input  logic                pair_i,
  input  logic [2*BYTE_W-1:0] mark_i,
  output match_e              match_o
);

  logic [BYTE_W-1:0] first_b;
  logic [BYTE_W-1:0] second_b;
  logic              lo_hit;
  logic              hi_hit;

  assign first_b  = mark_i[BYTE_W-1:0];
  assign second_b = mark_i[2*BYTE_W-1:BYTE_W];

  always_comb begin
    if (pair_i) begin
      lo_hit = (lo_i == first_b) && (hi_i == second_b);
    end else begin
      lo_hit = (lo_i == first_b);
    end
    hi_hit = (hi_i == first_b);
  end

  // The lower byte is the earlier one, so it takes priority.
  always_comb begin
    if (lo_hit)      match_o = MT_LOW;
    else if (hi_hit) match_o = MT_HIGH;
    else             match_o = MT_NONE;
  end

endmodule

// File: rtl/bo_arm_ctrl.sv
module bo_arm_ctrl
  import bo_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_i,
  input  logic   xfer_i,
  input  match_e match_i,
  output logic   search_o,
  output logic   pad_sel_o,
  output logic   pad_ins_o,
  output logic   hit_o,
  output logic   ordered_o
);

  logic sync_q;
  logic armed_q;
  logic ordered_q;
  logic rise;

  assign rise      = sync_i & ~sync_q;
  assign search_o  = sync_i & (armed_q | rise);
  assign pad_sel_o = search_o & (match_i == MT_HIGH);
  assign hit_o     = search_o & xfer_i & (match_i != MT_NONE);
  assign pad_ins_o = pad_sel_o & xfer_i;
  assign ordered_o = ordered_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 1'b0;
      armed_q   <= 1'b0;
      ordered_q <= 1'b0;
    end else begin
      sync_q <= sync_i;
      if (!sync_i) begin
        armed_q   <= 1'b0;
        ordered_q <= 1'b0;
      end else begin
        if (rise)  armed_q <= 1'b1;
        if (hit_o) begin
          armed_q   <= 1'b0;
          ordered_q <= 1'b1;
        end
      end
    end
  end

  AST_SYNC_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> !ordered_q); // R7

  AST_ORDERED_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ordered_q) |-> $past(xfer_i)); // R3

endmodule

// File: rtl/bo_slip_path.sv
module bo_slip_path #(
  parameter int BYTE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              xfer_i,
  input  logic              pad_sel_i,
  input  logic              pad_ins_i,
  input  logic [BYTE_W-1:0] pad_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic [BYTE_W-1:0] lo_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o,
  output logic              shifted_o
);

  logic              shift_q;
  logic [BYTE_W-1:0] hold_q;
  logic              eff_shift;

  assign eff_shift = sync_i & shift_q;
  assign shifted_o = eff_shift;

  always_comb begin
    if (pad_sel_i) begin
      hi_o = pad_i;
      lo_o = lo_i;
    end else if (eff_shift) begin
      hi_o = lo_i;
      lo_o = hold_q;
    end else begin
      hi_o = hi_i;
      lo_o = lo_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      if (!sync_i) begin
        shift_q <= 1'b0;
      end else if (pad_ins_i) begin
        shift_q <= 1'b1;
      end
      if (xfer_i) hold_q <= hi_i;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_i |=> $stable(hold_q)); // R10

  AST_SHIFT_FROM_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_q) |-> $past(pad_ins_i)); // R4

endmodule

// File: rtl/byte_order_aligner.sv
module byte_order_aligner
  import bo_pkg::*;
#(
  parameter int BYTE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_i,
  input  logic                cfg_pair_i,
  input  logic [2*BYTE_W-1:0] cfg_mark_i,
  input  logic [BYTE_W-1:0]   cfg_pad_i,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [2*BYTE_W-1:0] s_data,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [2*BYTE_W-1:0] m_data,
  output logic                ordered_o
);

  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] in_hi;
  logic [BYTE_W-1:0] in_lo;
  logic [BYTE_W-1:0] out_hi;
  logic [BYTE_W-1:0] out_lo;
  logic              xfer;
  logic              search;
  logic              pad_sel;
  logic              pad_ins;
  logic              hit;
  logic              shifted;
  match_e            match;

  assign in_hi   = s_data[WORD_W-1:BYTE_W];
  assign in_lo   = s_data[BYTE_W-1:0];
  assign xfer    = s_valid & m_ready;
  assign s_ready = m_ready;
  assign m_valid = s_valid;
  assign m_data  = {out_hi, out_lo};

  bo_marker_cmp #(.BYTE_W(BYTE_W)) cmp_i (
    .hi_i    (in_hi),
    .lo_i    (in_lo),
    .pair_i  (cfg_pair_i),
    .mark_i  (cfg_mark_i),
    .match_o (match)
  );

  bo_arm_ctrl arm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync_i),
    .xfer_i    (xfer),
    .match_i   (match),
    .search_o  (search),
    .pad_sel_o (pad_sel),
    .pad_ins_o (pad_ins),
    .hit_o     (hit),
    .ordered_o (ordered_o)
  );

  bo_slip_path #(.BYTE_W(BYTE_W)) slip_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync_i),
    .xfer_i    (xfer),
    .pad_sel_i (pad_sel),
    .pad_ins_i (pad_ins),
    .pad_i     (cfg_pad_i),
    .hi_i      (in_hi),
    .lo_i      (in_lo),
    .hi_o      (out_hi),
    .lo_o      (out_lo),
    .shifted_o (shifted)
  );

  AST_ONE_PAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pad_ins |-> !shifted); // R6

  AST_ORDER_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (search && xfer && match != MT_NONE) |=> ordered_o); // R3

  AST_NO_PAD_OUTSIDE_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    !search |-> !hit); // R2

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !m_ready) ##1 ($stable(s_data) && $stable(sync_i) && sync_i)
      |-> $stable(m_data)); // R10

endmodule

// File: tb/byte_order_aligner_tb_top.sv
module byte_order_aligner_tb_top;

  localparam int W  = 9;
  localparam int NV = 26;

  typedef struct packed {
    logic         sync;
    logic         vld;
    logic         rdy;
    logic         pair;
    logic [W-1:0] hi;
    logic [W-1:0] lo;
    logic [W-1:0] ehi;
    logic [W-1:0] elo;
    logic         eord;
  } vec_t;

  // Marker A = 1BC, pair second byte B = 13C, pad = 1F7
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b1,1'b0, 9'h011,9'h022, 9'h011,9'h022, 1'b0}, // R1 pass while idle
    '{1'b1,1'b1,1'b1,1'b0, 9'h033,9'h044, 9'h033,9'h044, 1'b0}, // R2 rise, no match
    '{1'b1,1'b1,1'b1,1'b0, 9'h0BC,9'h055, 9'h0BC,9'h055, 1'b0}, // R11 flag differs
    '{1'b1,1'b1,1'b1,1'b0, 9'h1BC,9'h066, 9'h1F7,9'h066, 1'b0}, // R4 pad
    '{1'b1,1'b1,1'b1,1'b0, 9'h077,9'h088, 9'h088,9'h1BC, 1'b1}, // R5 shifted
    '{1'b1,1'b1,1'b1,1'b0, 9'h099,9'h1BC, 9'h1BC,9'h077, 1'b1}, // R6 later match ignored
    '{1'b0,1'b1,1'b1,1'b0, 9'h0AA,9'h0AB, 9'h0AA,9'h0AB, 1'b1}, // R7 sync low pass
    '{1'b0,1'b1,1'b1,1'b0, 9'h0AC,9'h0AD, 9'h0AC,9'h0AD, 1'b0}, // R7 status cleared
    '{1'b1,1'b1,1'b1,1'b0, 9'h0AE,9'h1BC, 9'h0AE,9'h1BC, 1'b0}, // R3 lower match
    '{1'b1,1'b1,1'b1,1'b0, 9'h1BC,9'h0B0, 9'h1BC,9'h0B0, 1'b1}, // R6 no pad later
    '{1'b0,1'b1,1'b1,1'b0, 9'h001,9'h002, 9'h001,9'h002, 1'b1}, // R7
    '{1'b1,1'b1,1'b0,1'b0, 9'h1BC,9'h003, 9'h1F7,9'h003, 1'b0}, // R10 stall
    '{1'b1,1'b1,1'b1,1'b0, 9'h1BC,9'h003, 9'h1F7,9'h003, 1'b0}, // R10 search kept
    '{1'b1,1'b1,1'b1,1'b0, 9'h004,9'h005, 9'h005,9'h1BC, 1'b1}, // R5
    '{1'b1,1'b0,1'b1,1'b0, 9'h006,9'h007, 9'h007,9'h004, 1'b1}, // R10 no xfer
    '{1'b1,1'b1,1'b1,1'b0, 9'h008,9'h009, 9'h009,9'h004, 1'b1}, // R10 hold unchanged
    '{1'b0,1'b1,1'b1,1'b1, 9'h010,9'h011, 9'h010,9'h011, 1'b1}, // R7
    '{1'b1,1'b1,1'b1,1'b1, 9'h000,9'h1BC, 9'h000,9'h1BC, 1'b0}, // R8 half pair
    '{1'b1,1'b1,1'b1,1'b1, 9'h13C,9'h1BC, 9'h13C,9'h1BC, 1'b0}, // R8 full pair low
    '{1'b1,1'b1,1'b1,1'b1, 9'h012,9'h013, 9'h012,9'h013, 1'b1}, // R8 ordered
    '{1'b0,1'b1,1'b1,1'b1, 9'h014,9'h015, 9'h014,9'h015, 1'b1}, // R7
    '{1'b1,1'b1,1'b1,1'b1, 9'h1BC,9'h016, 9'h1F7,9'h016, 1'b0}, // R8 upper pad
    '{1'b1,1'b1,1'b1,1'b1, 9'h017,9'h13C, 9'h13C,9'h1BC, 1'b1}, // R8 pair now low
    '{1'b0,1'b1,1'b1,1'b0, 9'h018,9'h019, 9'h018,9'h019, 1'b1}, // R7
    '{1'b1,1'b1,1'b1,1'b0, 9'h1BC,9'h1BC, 9'h1BC,9'h1BC, 1'b0}, // R9 both match
    '{1'b1,1'b1,1'b1,1'b0, 9'h020,9'h021, 9'h020,9'h021, 1'b1}  // R9 ordered
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic           sync_i;
  logic           cfg_pair_i;
  logic [2*W-1:0] cfg_mark_i;
  logic [W-1:0]   cfg_pad_i;
  logic           s_valid;
  logic           s_ready;
  logic [2*W-1:0] s_data;
  logic           m_valid;
  logic           m_ready;
  logic [2*W-1:0] m_data;
  logic           ordered_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  byte_order_aligner #(.BYTE_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .cfg_pair_i(cfg_pair_i),
    .cfg_mark_i(cfg_mark_i), .cfg_pad_i(cfg_pad_i), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .ordered_o(ordered_o)
  );

  task automatic check(input string req, input logic [2*W+2:0] act,
                       input logic [2*W+2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic sy, input logic [W-1:0] hi,
                       input logic [W-1:0] lo);
    @(negedge clk);
    sync_i  = sy;
    s_valid = 1'b1;
    m_ready = 1'b1;
    s_data  = {hi, lo};
    #1;
  endtask

  initial begin
    rst_n      = 1'b0;
    sync_i     = 1'b0;
    cfg_pair_i = 1'b0;
    cfg_mark_i = {9'h13C, 9'h1BC};
    cfg_pad_i  = 9'h1F7;
    s_valid    = 1'b0;
    m_ready    = 1'b1;
    s_data     = '0;
    repeat (3) @(negedge clk);
    s_valid = 1'b1;
    s_data  = {9'h1BC, 9'h031};
    #1;
    // R1: reset state, pass-through, status low
    check("R1 reset", {m_valid, s_ready, ordered_o, m_data},
          {1'b1, 1'b1, 1'b0, 9'h1BC, 9'h031});
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sync_i     = TBL[i].sync;
      s_valid    = TBL[i].vld;
      m_ready    = TBL[i].rdy;
      cfg_pair_i = TBL[i].pair;
      s_data     = {TBL[i].hi, TBL[i].lo};
      #1;
      check($sformatf("table row %0d", i),
            {m_valid, s_ready, ordered_o, m_data},
            {TBL[i].vld, TBL[i].rdy, TBL[i].eord, TBL[i].ehi, TBL[i].elo});
    end

    // R1: reset in the middle of a shifted stream
    drive(1'b0, 9'h040, 9'h041);
    drive(1'b1, 9'h1BC, 9'h042);
    check("R4 pad before reset", {3'b110, m_data}, {3'b110, 9'h1F7, 9'h042});
    drive(1'b1, 9'h043, 9'h044);
    check("R5 shifted before reset", {2'b11, ordered_o, m_data},
          {2'b11, 1'b1, 9'h044, 9'h1BC});
    rst_n = 1'b0;
    #1;
    check("R1 reset clears status and slip", {2'b11, ordered_o, m_data},
          {2'b11, 1'b0, 9'h043, 9'h044});
    drive(1'b1, 9'h045, 9'h046);
    rst_n = 1'b1;
    drive(1'b1, 9'h047, 9'h048);
    check("R1 pass after reset", {2'b11, ordered_o, m_data},
          {2'b11, 1'b0, 9'h047, 9'h048});

    // R2: no new search without a fresh rising edge
    drive(1'b1, 9'h1BC, 9'h049);
    check("R2 armed by post-reset rise", {3'b110, m_data}, {3'b110, 9'h1F7, 9'h049});
    drive(1'b0, 9'h050, 9'h051);
    drive(1'b0, 9'h052, 9'h053);
    drive(1'b1, 9'h054, 9'h055);
    drive(1'b1, 9'h056, 9'h1BC);
    drive(1'b1, 9'h1BC, 9'h057);
    check("R2 R6 no pad after handled match", {2'b11, ordered_o, m_data},
          {2'b11, 1'b1, 9'h1BC, 9'h057});

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule